// File: doc/BRIEF.md
# Oscillator Tuning Word Bank

This block holds the tuning words of a numerically controlled oscillator. On every clock it gives the phase accumulator one increment. A host loads the wide words through a byte-wide port. Each byte goes into a staging register. A commit strobe then copies the whole staged word into one of two frequency words, in a single edge. Because of this, the accumulator never sees a word that is only partly loaded.

A keying input picks which of the two frequency words is the centre frequency. This gives frequency-shift keying. The keying input may change at any time relative to the oscillator clock, so it passes through a two-flop synchroniser before it takes effect.

A signed deviation register is sign-extended and added to the selected word. Acquisition clears it to zero, and a tracking loop then writes it at full width. The sum wraps modulo 2^ACC_W and is registered before it leaves the block.

Top module: `nco_tune_bank`

## Requirements
- R1: A byte write with `wrEn` high puts `wrData` into staging byte `wrAddr`. Byte k occupies bits 8k+7:8k. The other staging bytes keep their values, and `incr` does not change because of the write.
- R2: A `commit` pulse copies the whole staging word into frequency word 0 when `commitTgt`=0, or into word 1 when `commitTgt`=1, in one edge. The other word does not change. A byte write in the same cycle as a commit reaches the staging register only after the copy.
- R3: `incr` is registered. A change to a frequency word or to the deviation on one edge appears on `incr` after the next edge.
- R4: `incr` equals the selected frequency word plus the sign-extended two's-complement deviation, modulo 2^ACC_W. Selection value 0 picks word 0 and value 1 picks word 1.
- R5: `devLd` loads `devIn` into the deviation register. `devClr` sets the deviation to zero and wins over `devLd` in the same cycle.
- R6: `fskSelAsync` goes through two flip-flops. A change sampled on edge 1 drives the selection after edge 2 and appears on `incr` after edge 3.
- R7: After reset, the staging register, both frequency words, the deviation, the synchroniser and `incr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Byte write strobe to the staging register |
| wrAddr | input | ADDR_W | Index of the staging byte to write |
| wrData | input | BUS_W | Byte value |
| commit | input | 1 | Copy the staging word into the targeted frequency word |
| commitTgt | input | 1 | Target frequency word: 0 or 1 |
| devLd | input | 1 | Load the deviation register |
| devClr | input | 1 | Clear the deviation register (has priority) |
| devIn | input | DEV_W | Signed deviation value |
| fskSelAsync | input | 1 | Asynchronous keying select |
| incr | output | ACC_W | Registered increment to the phase accumulator |

## Verification
The assertions assume that every input except `fskSelAsync` is synchronous to `clk`. They also assume that each control strobe stays low while reset is asserted. The keying assertion assumes `fskSelAsync` holds each value for at least one full cycle, so that the second synchroniser stage copies a sampled value. The bench drives every input on the falling edge and holds each keying level for several cycles. This keeps all stimulus inside those assumptions.

// File: rtl/nco_tune_pkg.sv
package nco_tune_pkg;
  typedef struct packed {
    logic commit0;
    logic commit1;
    logic devClr;
    logic devLd;
    logic selWord;
  } tuneStrobes_t;
endpackage

// File: rtl/nco_tune_ctrl.sv
module nco_tune_ctrl
  import nco_tune_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              commit,
  input  logic              commitTgt,
  input  logic              devLd,
  input  logic              devClr,
  input  logic              fskSelAsync,
  output tuneStrobes_t      stb,
  output logic [BYTES-1:0]  byteEn
);
  logic syncA, syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= fskSelAsync;
      syncB <= syncA;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byteDec
    assign byteEn[b] = wrEn && (wrAddr == ADDR_W'(b));
  end

  always_comb begin
    stb.commit0 = commit && !commitTgt;
    stb.commit1 = commit && commitTgt;
    stb.devClr  = devClr;
    stb.devLd   = devLd && !devClr;
    stb.selWord = syncB;
  end
endmodule

// File: rtl/nco_tune_dp.sv
module nco_tune_dp
  import nco_tune_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int BUS_W = 8,
  parameter int DEV_W = 16,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tuneStrobes_t     stb,
  input  logic [BYTES-1:0] byteEn,
  input  logic [BUS_W-1:0] wrData,
  input  logic [DEV_W-1:0] devIn,
  output logic [ACC_W-1:0] holdQ,
  output logic [ACC_W-1:0] word0Q,
  output logic [ACC_W-1:0] word1Q,
  output logic [DEV_W-1:0] devQ,
  output logic [ACC_W-1:0] incr
);
  localparam int EXT_W = ACC_W - DEV_W;

  logic [ACC_W-1:0] devExt;
  logic [ACC_W-1:0] centre;

  for (genvar b = 0; b < BYTES; b++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         holdQ[b*BUS_W +: BUS_W] <= '0;
      else if (byteEn[b]) holdQ[b*BUS_W +: BUS_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word0Q <= '0;
      word1Q <= '0;
    end else begin
      if (stb.commit0) word0Q <= holdQ;
      if (stb.commit1) word1Q <= holdQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          devQ <= '0;
    else if (stb.devClr) devQ <= '0;
    else if (stb.devLd)  devQ <= devIn;
  end

  assign devExt = {{EXT_W{devQ[DEV_W-1]}}, devQ};
  assign centre = stb.selWord ? word1Q : word0Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) incr <= '0;
    else       incr <= centre + devExt;
  end
endmodule

// File: rtl/nco_tune_bank.sv
module nco_tune_bank
  import nco_tune_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int BUS_W = 8,
  parameter int DEV_W = 16,
  localparam int BYTES  = ACC_W / BUS_W,
  localparam int ADDR_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              commit,
  input  logic              commitTgt,
  input  logic              devLd,
  input  logic              devClr,
  input  logic [DEV_W-1:0]  devIn,
  input  logic              fskSelAsync,
  output logic [ACC_W-1:0]  incr
);
  tuneStrobes_t     stb;
  logic [BYTES-1:0] byteEn;
  logic [ACC_W-1:0] holdQ, word0Q, word1Q;
  logic [DEV_W-1:0] devQ;

  nco_tune_ctrl #(.BYTES(BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .commit(commit), .commitTgt(commitTgt), .devLd(devLd), .devClr(devClr),
    .fskSelAsync(fskSelAsync), .stb(stb), .byteEn(byteEn)
  );

  nco_tune_dp #(.ACC_W(ACC_W), .BUS_W(BUS_W), .DEV_W(DEV_W), .BYTES(BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .byteEn(byteEn), .wrData(wrData),
    .devIn(devIn), .holdQ(holdQ), .word0Q(word0Q), .word1Q(word1Q),
    .devQ(devQ), .incr(incr)
  );
endmodule

// File: rtl/nco_tune_chk.sv
module nco_tune_chk
  import nco_tune_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int DEV_W = 16,
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rstN,
  input tuneStrobes_t     stb,
  input logic [BYTES-1:0] byteEn,
  input logic [ACC_W-1:0] holdQ,
  input logic [ACC_W-1:0] word0Q,
  input logic [ACC_W-1:0] word1Q,
  input logic [DEV_W-1:0] devQ,
  input logic [ACC_W-1:0] incr,
  input logic             fskSelAsync
);
  p_one_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(byteEn));

  p_hold_keep_r1: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn == '0) |=> $stable(holdQ));

  p_copy0_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit0 |=> (word0Q == $past(holdQ)));

  p_copy1_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit1 |=> (word1Q == $past(holdQ)));

  p_word0_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit0 |=> $stable(word0Q));

  p_word1_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit1 |=> $stable(word1Q));

  p_incr_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(word0Q) && $stable(word1Q) && $stable(devQ) && $stable(stb.selWord))
      |=> $stable(incr));

  p_dev_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.devClr |=> (devQ == '0));

  p_sel_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.selWord) |-> $past(fskSelAsync, 2));
endmodule

bind nco_tune_bank nco_tune_chk #(.ACC_W(ACC_W), .DEV_W(DEV_W), .BYTES(BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .byteEn(byteEn), .holdQ(holdQ),
  .word0Q(word0Q), .word1Q(word1Q), .devQ(devQ), .incr(incr),
  .fskSelAsync(fskSelAsync)
);

// File: tb/nco_tune_bank_bench.sv
module nco_tune_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        commit = 1'b0;
  logic        commitTgt = 1'b0;
  logic        devLd = 1'b0;
  logic        devClr = 1'b0;
  logic [15:0] devIn = '0;
  logic        fskSelAsync = 1'b0;
  logic [31:0] incr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nco_tune_bank u_nco_tune_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .commit(commit), .commitTgt(commitTgt), .devLd(devLd), .devClr(devClr),
    .devIn(devIn), .fskSelAsync(fskSelAsync), .incr(incr)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeByte(logic [1:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic stageWord(logic [31:0] w);
    for (int b = 0; b < 4; b++) writeByte(2'(b), w[b*8 +: 8]);
  endtask

  task automatic commitTo(logic t);
    commit = 1'b1; commitTgt = t;
    step();
    commit = 1'b0;
  endtask

  task automatic loadDev(logic [15:0] v);
    devLd = 1'b1; devIn = v;
    step();
    devLd = 1'b0;
  endtask

  task automatic testReset();
    step(2);
    check("R7 reset incr", incr, 32'h0);
    rstN = 1'b1;
    step(2);
    check("R7 zero after release", incr, 32'h0);
  endtask

  task automatic testStageCommit();
    stageWord(32'h1234_5678);
    check("R1 staging leaves incr", incr, 32'h0);
    commitTo(1'b0);
    check("R3 not yet on incr", incr, 32'h0);
    step();
    check("R2 word0 whole word", incr, 32'h1234_5678);
    writeByte(2'd2, 8'hAB);
    step();
    check("R1 byte write no effect", incr, 32'h1234_5678);
    commitTo(1'b0);
    step();
    check("R1 byte2 position", incr, 32'h12AB_5678);
  endtask

  task automatic testWord1AndSameCycle();
    stageWord(32'h0000_0100);
    commitTo(1'b1);
    step();
    check("R2 word1 load leaves word0", incr, 32'h12AB_5678);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h55;
    commit = 1'b1; commitTgt = 1'b0;
    step();
    wrEn = 1'b0; commit = 1'b0;
    step();
    check("R2 commit takes old staging", incr, 32'h0000_0100);
    commitTo(1'b0);
    step();
    check("R2 later commit sees write", incr, 32'h0000_0155);
  endtask

  task automatic testFsk();
    fskSelAsync = 1'b1;
    step(2);
    check("R6 two edges still word0", incr, 32'h0000_0155);
    step();
    check("R6 third edge word1", incr, 32'h0000_0100);
    fskSelAsync = 1'b0;
    step(3);
    check("R6 back to word0", incr, 32'h0000_0155);
  endtask

  task automatic testDev();
    stageWord(32'hFFFF_FFF0);
    commitTo(1'b0);
    loadDev(16'h0020);
    step();
    check("R4 wrap modulo", incr, 32'h0000_0010);
    fskSelAsync = 1'b1;
    step(2);
    loadDev(16'hFFFF);
    step();
    check("R4 negative deviation", incr, 32'h0000_00FF);
    loadDev(16'h8000);
    step();
    check("R4 sign extension", incr, 32'hFFFF_8100);
    devClr = 1'b1; devLd = 1'b1; devIn = 16'h0007;
    step();
    devClr = 1'b0; devLd = 1'b0;
    step();
    check("R5 clear wins over load", incr, 32'h0000_0100);
    loadDev(16'h0003);
    step();
    check("R5 load after clear", incr, 32'h0000_0103);
  endtask

  initial begin
    testReset();
    testStageCommit();
    testWord1AndSameCycle();
    testFsk();
    testDev();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule